// File: doc/BRIEF.md
# Packed 2-bit Index Table Expander

This block turns a vector of packed 2-bit codes into a vector of wider elements by looking each code up in a small table. The table arrives as a 512-bit word that holds sixteen 32-bit entries. The codes arrive as a VL-bit source vector. A 2-bit width code chooses 8-, 16- or 32-bit output elements. A 4-bit segment immediate chooses which slice of the source vector supplies the codes, wrapped by the number of slices that fit at that width. Each output element takes the low bits of the table entry that its code names. Every element of the destination is written on each operation.

A caller pulses the strobe for one cycle with all operands stable. One clock later the expanded vector appears with a one-cycle valid flag. If the width code is the reserved value, an undefined-operation flag pulses instead and the output vector keeps its old contents. VL is a compile-time parameter that must be a multiple of 32.

Top module: `idx2_table_expander`

## Requirements
- R1: Width code 00 gives 8-bit elements. There are VL/8 elements and 4 slices, and the slice used is the immediate mod 4. Element e is the low 8 bits of table entry k, where entry k sits at table bits [32k+31:32k]. Its code is the 2-bit field at source bits [2(s·n+e)+1 : 2(s·n+e)], with s the slice and n the element count.
- R2: Width code 01 gives 16-bit elements. There are VL/16 elements and 8 slices, and the slice used is the immediate mod 8. Codes and entries are placed as in R1.
- R3: Width code 10 gives 32-bit elements. There are VL/32 elements and 16 slices, and the slice used is the full immediate. Codes and entries are placed as in R1.
- R4: Width code 11 is reserved. A strobe with it raises out_undef for exactly the next cycle, keeps out_valid low and leaves out_vec unchanged.
- R5: A strobe with a legal width code raises out_valid in the next cycle only. out_vec carries the result in that same cycle.
- R6: Table entries 4 to 15 never affect the result.
- R7: Without a strobe, out_valid and out_undef are low in the next cycle and out_vec keeps its value.
- R8: After reset, out_valid and out_undef are low and out_vec is all zeros.
- R9: out_valid and out_undef are never high together.
- R10: Immediates that are equal modulo the slice count give identical results. For example, with 8-bit elements immediates 5 and 1 give the same vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle operation strobe |
| size_code | input | 2 | Element width code (00=8, 01=16, 10=32, 11 reserved) |
| seg_imm | input | 4 | Segment immediate, 0 to 15 |
| index_vec | input | VL | Packed 2-bit codes |
| table_vec | input | 512 | Sixteen 32-bit table entries, entry 0 lowest |
| out_valid | output | 1 | Result valid, one cycle after a legal strobe |
| out_undef | output | 1 | Reserved width code seen, one cycle after the strobe |
| out_vec | output | VL | Expanded result vector |

## Verification
The assertions check the control behaviour on every cycle. This covers the one-cycle latency of both flags, their mutual exclusion, the silence after a cycle with no strobe, and the output vector holding still whenever no result is written. The element values themselves are checked only by the bench's scenarios. Those scenarios cover every width code and every immediate against a reference model, and they show the modulo wrap by comparing two immediates. They also show that the upper table entries have no effect, by changing those entries and comparing the two results.

// File: rtl/idx2_pkg.sv
package idx2_pkg;
    localparam int TBL_W     = 512;
    localparam int ENTRY_W   = 32;
    localparam int CODE_W    = 2;
    localparam int REACH     = 1 << CODE_W;   // entries a code can name
    localparam int NUM_WIDTH = 3;             // legal element widths

    typedef enum logic [1:0] {
        WID_8   = 2'b00,
        WID_16  = 2'b01,
        WID_32  = 2'b10,
        WID_RSV = 2'b11
    } width_code_e;
endpackage

// File: rtl/idx2_size_decode.sv
module idx2_size_decode
    import idx2_pkg::*;
(
    input  logic [1:0]           size_code,
    output logic [NUM_WIDTH-1:0] width_sel,
    output logic                 reserved
);
    always_comb begin
        width_sel = '0;
        reserved  = 1'b0;
        case (width_code_e'(size_code))
            WID_8:   width_sel[0] = 1'b1;
            WID_16:  width_sel[1] = 1'b1;
            WID_32:  width_sel[2] = 1'b1;
            default: reserved     = 1'b1;
        endcase
    end
endmodule

// File: rtl/idx2_lane_bank.sv
module idx2_lane_bank
    import idx2_pkg::*;
#(
    parameter int VL = 512,
    parameter int EW = 8
) (
    input  logic [3:0]                 seg_imm,
    input  logic [VL-1:0]              index_vec,
    input  logic [REACH-1:0][EW-1:0]   entries,
    output logic [VL-1:0]              lanes
);
    localparam int N_ELEM   = VL / EW;
    localparam int N_SEG    = EW / CODE_W;
    localparam int SEG_BITS = CODE_W * N_ELEM;
    localparam int SH_W     = $clog2(VL) + 1;

    logic [3:0]          seg;
    logic [SH_W-1:0]     shamt;
    logic [VL-1:0]       shifted;
    logic [SEG_BITS-1:0] seg_field;

    // slice number wraps on the slice count (always a power of two)
    assign seg       = seg_imm & 4'(N_SEG - 1);
    assign shamt     = SH_W'(seg) * SH_W'(SEG_BITS);
    assign shifted   = index_vec >> shamt;
    assign seg_field = shifted[SEG_BITS-1:0];

    for (genvar e = 0; e < N_ELEM; e++) begin : g_lane
        logic [CODE_W-1:0] code;
        assign code               = seg_field[e*CODE_W +: CODE_W];
        assign lanes[e*EW +: EW]  = entries[code];
    end
endmodule

// File: rtl/idx2_table_expander.sv
module idx2_table_expander
    import idx2_pkg::*;
#(
    parameter int VL = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        size_code,
    input  logic [3:0]        seg_imm,
    input  logic [VL-1:0]     index_vec,
    input  logic [TBL_W-1:0]  table_vec,
    output logic              out_valid,
    output logic              out_undef,
    output logic [VL-1:0]     out_vec
);
    localparam int REACH_BITS = REACH * ENTRY_W;

    typedef struct packed {
        logic          valid;
        logic          undef;
        logic [VL-1:0] data;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_WIDTH-1:0]          width_sel;
    logic                          reserved;
    logic [NUM_WIDTH-1:0][VL-1:0]  bank_out;
    logic [VL-1:0]                 picked;

    // entries past the reach of a 2-bit code never feed the datapath
    logic unused_upper;
    assign unused_upper = ^table_vec[TBL_W-1:REACH_BITS];

    idx2_size_decode u_dec (
        .size_code (size_code),
        .width_sel (width_sel),
        .reserved  (reserved)
    );

    for (genvar g = 0; g < NUM_WIDTH; g++) begin : g_width
        localparam int EW = 8 << g;
        logic [REACH-1:0][EW-1:0] ent;
        for (genvar k = 0; k < REACH; k++) begin : g_ent
            assign ent[k] = table_vec[k*ENTRY_W +: EW];
        end
        idx2_lane_bank #(.VL(VL), .EW(EW)) u_bank (
            .seg_imm   (seg_imm),
            .index_vec (index_vec),
            .entries   (ent),
            .lanes     (bank_out[g])
        );
    end

    always_comb begin
        picked = '0;
        for (int g = 0; g < NUM_WIDTH; g++) begin
            if (width_sel[g]) picked = picked | bank_out[g];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.undef = 1'b0;
        if (in_valid) begin
            if (reserved) begin
                st_d.undef = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.data  = picked;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_undef = st_q.undef;
    assign out_vec   = st_q.data;
endmodule

// File: rtl/idx2_expander_chk.sv
module idx2_expander_chk #(
    parameter int VL = 512
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    size_code,
    input logic          out_valid,
    input logic          out_undef,
    input logic [VL-1:0] out_vec
);
    assert_rsv_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 2'b11) |=> (out_undef && !out_valid));

    assert_rsv_keeps_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 2'b11) |=> $stable(out_vec));

    assert_legal_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code != 2'b11) |=> (out_valid && !out_undef));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_undef));

    assert_hold_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_vec));

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_undef}));
endmodule

bind idx2_table_expander idx2_expander_chk #(.VL(VL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .size_code (size_code),
    .out_valid (out_valid),
    .out_undef (out_undef),
    .out_vec   (out_vec)
);

// File: tb/test_idx2_table_expander.sv
module test_idx2_table_expander;
    localparam int VL  = 512;
    localparam int TBW = 512;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [1:0]     size_code = '0;
    logic [3:0]     seg_imm = '0;
    logic [VL-1:0]  index_vec = '0;
    logic [TBW-1:0] table_vec = '0;
    logic           out_valid, out_undef;
    logic [VL-1:0]  out_vec;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    idx2_table_expander #(.VL(VL)) i_idx2_table_expander (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
        .seg_imm(seg_imm), .index_vec(index_vec), .table_vec(table_vec),
        .out_valid(out_valid), .out_undef(out_undef), .out_vec(out_vec)
    );

    function automatic logic [VL-1:0] ref_expand(input logic [1:0] sz, input logic [3:0] imm,
                                                 input logic [VL-1:0] idx, input logic [TBW-1:0] tbl);
        logic [VL-1:0] r = '0;
        int w    = 8 << sz;
        int n    = VL / w;
        int segs = w / 2;
        int s    = imm % segs;
        for (int e = 0; e < n; e++) begin
            int k = int'(idx[2*(s*n+e) +: 2]);
            for (int b = 0; b < w; b++) r[e*w+b] = tbl[32*k+b];
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rand_vl();
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [TBW-1:0] rand_tbl();
        logic [TBW-1:0] v;
        for (int i = 0; i < TBW/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_bit(input string req, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [VL-1:0] got, input logic [VL-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one strobe; returns with outputs of that strobe visible (mid-cycle)
    task automatic run_op(input logic [1:0] sz, input logic [3:0] imm,
                          input logic [VL-1:0] idx, input logic [TBW-1:0] tbl);
        @(negedge clk);
        size_code = sz; seg_imm = imm; index_vec = idx; table_vec = tbl;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R8 valid", out_valid, 1'b0);
        check_bit("R8 undef", out_undef, 1'b0);
        check_vec("R8 data", out_vec, '0);
    endtask

    task automatic t_width(input logic [1:0] sz, input string req);
        for (int imm = 0; imm < 16; imm++) begin
            logic [VL-1:0]  idx = rand_vl();
            logic [TBW-1:0] tbl = rand_tbl();
            run_op(sz, 4'(imm), idx, tbl);
            check_vec($sformatf("%s imm=%0d", req, imm), out_vec, ref_expand(sz, 4'(imm), idx, tbl));
            check_bit($sformatf("R5 valid imm=%0d", imm), out_valid, 1'b1);
        end
    endtask

    task automatic t_wrap();
        logic [VL-1:0]  idx = rand_vl();
        logic [TBW-1:0] tbl = rand_tbl();
        logic [VL-1:0]  a;
        run_op(2'b00, 4'd1, idx, tbl);
        a = out_vec;
        run_op(2'b00, 4'd5, idx, tbl);
        check_vec("R10 imm5 vs imm1", out_vec, a);
        run_op(2'b01, 4'd11, idx, tbl);
        a = out_vec;
        run_op(2'b01, 4'd3, idx, tbl);
        check_vec("R10 imm11 vs imm3 16-bit", out_vec, a);
    endtask

    task automatic t_reserved();
        logic [VL-1:0] prev;
        run_op(2'b10, 4'd7, rand_vl(), rand_tbl());
        prev = out_vec;
        run_op(2'b11, 4'd2, rand_vl(), rand_tbl());
        check_bit("R4 undef", out_undef, 1'b1);
        check_bit("R4 valid low", out_valid, 1'b0);
        check_vec("R4 data kept", out_vec, prev);
        @(negedge clk);
        check_bit("R4 undef one cycle", out_undef, 1'b0);
    endtask

    task automatic t_high_entries();
        logic [VL-1:0]  idx = rand_vl();
        logic [TBW-1:0] tbl = rand_tbl();
        logic [VL-1:0]  a;
        run_op(2'b10, 4'd9, idx, tbl);
        a = out_vec;
        tbl[TBW-1:128] = ~tbl[TBW-1:128];
        run_op(2'b10, 4'd9, idx, tbl);
        check_vec("R6 upper entries ignored", out_vec, a);
    endtask

    task automatic t_idle();
        logic [VL-1:0] prev;
        run_op(2'b01, 4'd4, rand_vl(), rand_tbl());
        prev = out_vec;
        @(negedge clk);
        index_vec = rand_vl(); table_vec = rand_tbl();
        @(negedge clk);
        check_bit("R7 valid low", out_valid, 1'b0);
        check_bit("R9 undef low", out_undef, 1'b0);
        check_vec("R7 data held", out_vec, prev);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_width(2'b00, "R1");
        t_width(2'b01, "R2");
        t_width(2'b10, "R3");
        t_wrap();
        t_reserved();
        t_high_entries();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule